// File: doc/BRIEF.md
# Parallel-Evaluate ALU with Instruction Decode and Flag Capture

This block is an 8-bit arithmetic and logic unit in which every functional unit (adder, subtractor, the three bitwise arrays and two logical shifters) works on operands `a` and `b` in every cycle. A 3-bit operation code then picks one finished result through an output multiplexer. Because the choice is made last, the combinational delay is the same for every operation.

The operation code has two sources. In direct mode it is taken from the `op_sel` input. In instruction mode it comes from a fixed decode of a 16-bit two-register instruction word. That decode also splits out 5-bit source and destination register indices for the neighbouring register file.

When `en` is high, each clock edge captures the selected result and the Zero/Carry/Negative/Overflow flags together. In instruction mode, a word that matches no known pattern leaves both registers unchanged.

Top module: `parallel_alu`

## Requirements
- R1: Operation code 000 gives a+b, 001 gives a-b, 010 gives a&b, 011 gives a|b and 100 gives a^b, each truncated to 8 bits.
- R2: Code 101 is a logical left shift and 110 a logical right shift of `a` by `b[2:0]`, with zeros filling vacated bits. Carry holds the last bit shifted out (0 when the amount is 0) and Overflow is 0.
- R3: Code 111 (compare) outputs `a` unchanged and sets all four flags exactly as a-b would.
- R4: Zero is 1 when the 8-bit value the flags are taken from is all zeros. Negative is bit 7 of that value. That value is the selected result, or the difference for compare.
- R5: Carry is the unsigned carry-out of a+b for code 000, and the borrow (a < b unsigned) for codes 001 and 111.
- R6: Overflow is 1 when the signed two's-complement sum (000) or difference (001, 111) leaves the range -128..127. It is computed independently of Carry.
- R7: Codes 010, 011 and 100 clear Carry and Overflow.
- R8: `dec_valid` is 1 exactly when `instr[15:10]` is one of 000011 (add), 000110 (subtract), 001000 (and), 001010 (or) or 001001 (xor).
- R9: `src_idx` = {instr[9], instr[3:0]} and `dst_idx` = {instr[8], instr[7:4]}.
- R10: When `use_instr` is 1 the decoded operation is used and `op_sel` is ignored. When it is 0, `op_sel` is used whatever `instr` holds.
- R11: Result and flags load together on a rising edge with `en` high, and hold their values when `en` is low.
- R12: With `use_instr` high and `dec_valid` low, neither the result nor the flags change.
- R13: While `rst_n` is low, the result and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Capture enable for result and flags |
| use_instr | input | 1 | 1: operation from decoded instruction, 0: from op_sel |
| op_sel | input | 3 | Direct operation code |
| instr | input | 16 | Two-register instruction word |
| a | input | 8 | First operand |
| b | input | 8 | Second operand / shift amount |
| dec_valid | output | 1 | Instruction word matches a known pattern |
| src_idx | output | 5 | Decoded source register index |
| dst_idx | output | 5 | Decoded destination register index |
| result | output | 8 | Registered result |
| flag_z | output | 1 | Registered Zero flag |
| flag_c | output | 1 | Registered Carry/borrow flag |
| flag_n | output | 1 | Registered Negative flag |
| flag_v | output | 1 | Registered signed Overflow flag |

## Verification
The assertions check on every cycle that the registers hold when capture is off and when an instruction word is rejected. They also check, for any operand pair in direct mode, the sum, the borrow, the Zero and Negative taps, the cleared Carry/Overflow after logic operations, and that compare leaves `a` in the result. Only the bench scenarios can show the complete value tables: shift carries at every amount, signed overflow at the range edges, compare flags, the mapping of each instruction pattern onto the right operation, and the split register-index fields.

// File: rtl/palu_pkg.sv
package palu_pkg;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_XOR = 3'd4,
        ALU_SHL = 3'd5,
        ALU_SHR = 3'd6,
        ALU_CMP = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic c;
        logic n;
        logic v;
    } alu_flags_t;

    // Instruction decode: width of the matched top field and number of patterns
    localparam int OPC_TOP_W = 6;
    localparam int NUM_OPC   = 5;

endpackage

// File: rtl/palu_decode.sv
module palu_decode
    import palu_pkg::*;
#(
    parameter int INSTR_W = 16,
    parameter int IDX_W   = 5
) (
    input  logic [INSTR_W-1:0] instr,
    output alu_op_e            op,
    output logic               valid,
    output logic [IDX_W-1:0]   src_idx,
    output logic [IDX_W-1:0]   dst_idx
);

    localparam int TOP_LSB = INSTR_W - OPC_TOP_W;
    localparam int LOW_W   = IDX_W - 1;

    // Pattern table: top field value and the operation it maps to
    localparam logic [OPC_TOP_W-1:0] PAT_TOP [NUM_OPC] = '{
        6'b000011, 6'b000110, 6'b001000, 6'b001010, 6'b001001
    };
    localparam logic [2:0] PAT_OP [NUM_OPC] = '{
        3'd0, 3'd1, 3'd2, 3'd3, 3'd4
    };

    logic [OPC_TOP_W-1:0] top_field;
    logic [NUM_OPC-1:0]   hit;

    assign top_field = instr[INSTR_W-1:TOP_LSB];

    for (genvar g = 0; g < NUM_OPC; g++) begin : g_match
        assign hit[g] = (top_field == PAT_TOP[g]);
    end

    always_comb begin
        valid = |hit;
        op    = ALU_ADD;
        for (int i = 0; i < NUM_OPC; i++) begin
            if (hit[i]) op = alu_op_e'(PAT_OP[i]);
        end
    end

    // Split register fields: high bit sits above the opcode low bits
    assign src_idx = {instr[TOP_LSB-1], instr[LOW_W-1:0]};
    assign dst_idx = {instr[TOP_LSB-2], instr[2*LOW_W-1:LOW_W]};

endmodule

// File: rtl/palu_shifter.sv
module palu_shifter #(
    parameter int DATA_W  = 8,
    parameter bit LEFT    = 1'b1,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]  din,
    input  logic [SHAMT_W-1:0] amt,
    output logic [DATA_W-1:0]  dout,
    output logic               cout
);

    if (LEFT) begin : g_left
        logic [DATA_W:0] wide;
        // extra bit above the word catches the last bit pushed out
        assign wide = {1'b0, din} << amt;
        assign dout = wide[DATA_W-1:0];
        assign cout = wide[DATA_W];
    end else begin : g_right
        logic [DATA_W:0] wide;
        // extra bit below the word catches the last bit pushed out
        assign wide = {din, 1'b0} >> amt;
        assign dout = wide[DATA_W:1];
        assign cout = wide[0];
    end

endmodule

// File: rtl/palu_exec.sv
module palu_exec
    import palu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  alu_op_e           op,
    output logic [DATA_W-1:0] res,
    output alu_flags_t        flags
);

    localparam int SHAMT_W = $clog2(DATA_W);
    localparam int MSB     = DATA_W - 1;

    // Every unit evaluates in parallel
    logic [DATA_W:0]   sum_w;
    logic [DATA_W:0]   dif_w;
    logic [DATA_W-1:0] and_r, or_r, xor_r;
    logic [DATA_W-1:0] shl_r, shr_r;
    logic              shl_c, shr_c;
    logic              add_v, sub_v;

    assign sum_w = {1'b0, a} + {1'b0, b};
    assign dif_w = {1'b0, a} - {1'b0, b};
    assign and_r = a & b;
    assign or_r  = a | b;
    assign xor_r = a ^ b;
    assign add_v = (a[MSB] == b[MSB]) && (sum_w[MSB] != a[MSB]);
    assign sub_v = (a[MSB] != b[MSB]) && (dif_w[MSB] != a[MSB]);

    palu_shifter #(.DATA_W(DATA_W), .LEFT(1'b1), .SHAMT_W(SHAMT_W)) u_shl (
        .din  (a),
        .amt  (b[SHAMT_W-1:0]),
        .dout (shl_r),
        .cout (shl_c)
    );

    palu_shifter #(.DATA_W(DATA_W), .LEFT(1'b0), .SHAMT_W(SHAMT_W)) u_shr (
        .din  (a),
        .amt  (b[SHAMT_W-1:0]),
        .dout (shr_r),
        .cout (shr_c)
    );

    // Output multiplexer: flags follow only the selected path
    logic [DATA_W-1:0] tap;

    always_comb begin
        res     = a;
        tap     = a;
        flags.c = 1'b0;
        flags.v = 1'b0;
        unique case (op)
            ALU_ADD: begin
                res = sum_w[DATA_W-1:0]; tap = res;
                flags.c = sum_w[DATA_W]; flags.v = add_v;
            end
            ALU_SUB: begin
                res = dif_w[DATA_W-1:0]; tap = res;
                flags.c = dif_w[DATA_W]; flags.v = sub_v;
            end
            ALU_AND: begin res = and_r; tap = res; end
            ALU_OR:  begin res = or_r;  tap = res; end
            ALU_XOR: begin res = xor_r; tap = res; end
            ALU_SHL: begin res = shl_r; tap = res; flags.c = shl_c; end
            ALU_SHR: begin res = shr_r; tap = res; flags.c = shr_c; end
            ALU_CMP: begin
                res = a; tap = dif_w[DATA_W-1:0];
                flags.c = dif_w[DATA_W]; flags.v = sub_v;
            end
            default: begin res = a; tap = a; end
        endcase
        flags.z = (tap == '0);
        flags.n = tap[MSB];
    end

endmodule

// File: rtl/parallel_alu.sv
module parallel_alu
    import palu_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int INSTR_W = 16,
    parameter int IDX_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               use_instr,
    input  logic [2:0]         op_sel,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  a,
    input  logic [DATA_W-1:0]  b,
    output logic               dec_valid,
    output logic [IDX_W-1:0]   src_idx,
    output logic [IDX_W-1:0]   dst_idx,
    output logic [DATA_W-1:0]  result,
    output logic               flag_z,
    output logic               flag_c,
    output logic               flag_n,
    output logic               flag_v
);

    typedef struct packed {
        logic [DATA_W-1:0] res;
        alu_flags_t        flg;
    } cap_t;

    alu_op_e           dec_op;
    alu_op_e           op_eff;
    logic [DATA_W-1:0] exe_res;
    alu_flags_t        exe_flg;
    logic              load;
    cap_t              cap_d, cap_q;

    palu_decode #(.INSTR_W(INSTR_W), .IDX_W(IDX_W)) u_dec (
        .instr   (instr),
        .op      (dec_op),
        .valid   (dec_valid),
        .src_idx (src_idx),
        .dst_idx (dst_idx)
    );

    assign op_eff = use_instr ? dec_op : alu_op_e'(op_sel);

    palu_exec #(.DATA_W(DATA_W)) u_exe (
        .a     (a),
        .b     (b),
        .op    (op_eff),
        .res   (exe_res),
        .flags (exe_flg)
    );

    always_comb begin
        cap_d = cap_q;
        load  = en && (!use_instr || dec_valid);
        if (load) begin
            cap_d.res = exe_res;
            cap_d.flg = exe_flg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign result = cap_q.res;
    assign flag_z = cap_q.flg.z;
    assign flag_c = cap_q.flg.c;
    assign flag_n = cap_q.flg.n;
    assign flag_v = cap_q.flg.v;

endmodule

// File: rtl/palu_checker.sv
module palu_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              use_instr,
    input logic [2:0]        op_sel,
    input logic              dec_valid,
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b,
    input logic [DATA_W-1:0] result,
    input logic              flag_z,
    input logic              flag_c,
    input logic              flag_n,
    input logic              flag_v
);

    logic direct;
    assign direct = en && !use_instr;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(result) && $stable(flag_z) && $stable(flag_c) && $stable(flag_n) && $stable(flag_v)); // R11

    AST_BAD_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        en && use_instr && !dec_valid |=> $stable(result) && $stable(flag_z) && $stable(flag_c) && $stable(flag_n) && $stable(flag_v)); // R12

    AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        direct && op_sel == 3'd0 |=> result == DATA_W'($past(a) + $past(b))); // R1

    AST_SUB_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
        direct && op_sel == 3'd1 |=> flag_c == ($past(a) < $past(b))); // R5

    AST_ZERO_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        direct && op_sel != 3'd7 |=> flag_z == (result == '0)); // R4

    AST_NEG_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        direct && op_sel != 3'd7 |=> flag_n == result[DATA_W-1]); // R4

    AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        direct && (op_sel == 3'd2 || op_sel == 3'd3 || op_sel == 3'd4) |=> !flag_c && !flag_v); // R7

    AST_CMP_KEEPS_A: assert property (@(posedge clk) disable iff (!rst_n)
        direct && op_sel == 3'd7 |=> result == $past(a)); // R3

endmodule

bind parallel_alu palu_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .use_instr (use_instr),
    .op_sel    (op_sel),
    .dec_valid (dec_valid),
    .a         (a),
    .b         (b),
    .result    (result),
    .flag_z    (flag_z),
    .flag_c    (flag_c),
    .flag_n    (flag_n),
    .flag_v    (flag_v)
);

// File: tb/parallel_alu_test.sv
`timescale 1ns/1ps
module parallel_alu_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        use_instr = 1'b0;
    logic [2:0]  op_sel = 3'd0;
    logic [15:0] instr = 16'h0000;
    logic [7:0]  a = 8'h00;
    logic [7:0]  b = 8'h00;
    logic        dec_valid;
    logic [4:0]  src_idx, dst_idx;
    logic [7:0]  result;
    logic        flag_z, flag_c, flag_n, flag_v;

    int total = 0;
    int fails = 0;
    logic [11:0] exp_q = '0;   // {result, z, c, n, v}

    always #5 clk = ~clk;

    parallel_alu uut (
        .clk(clk), .rst_n(rst_n), .en(en), .use_instr(use_instr),
        .op_sel(op_sel), .instr(instr), .a(a), .b(b),
        .dec_valid(dec_valid), .src_idx(src_idx), .dst_idx(dst_idx),
        .result(result), .flag_z(flag_z), .flag_c(flag_c),
        .flag_n(flag_n), .flag_v(flag_v)
    );

    // Arithmetic reference: returns {out, z, c, n, v}
    function automatic logic [11:0] ref_op(input int op, input int x, input int y);
        int sx, sy, t, s, fv, outv, c, v;
        sx = (x > 127) ? x - 256 : x;
        sy = (y > 127) ? y - 256 : y;
        s = y % 8;
        c = 0; v = 0;
        case (op)
            0: begin t = sx + sy; fv = (x + y) % 256; c = (x + y > 255); v = (t > 127 || t < -128); end
            1, 7: begin t = sx - sy; fv = (x - y + 256) % 256; c = (x < y); v = (t > 127 || t < -128); end
            2: fv = x & y;
            3: fv = x | y;
            4: fv = x ^ y;
            5: begin fv = (x << s) % 256; c = (s == 0) ? 0 : (x >> (8 - s)) % 2; end
            default: begin fv = x >> s; c = (s == 0) ? 0 : (x >> (s - 1)) % 2; end
        endcase
        outv = (op == 7) ? x : fv;
        return {8'(outv), (fv == 0), 1'(c), 1'((fv >> 7) % 2), 1'(v)};
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [11:0] outs();
        return {result, flag_z, flag_c, flag_n, flag_v};
    endfunction

    function automatic string op_tag(input int op);
        case (op)
            0: return "R1/R4/R5/R6 add";
            1: return "R1/R4/R5/R6 sub";
            2, 3, 4: return "R1/R4/R7 logic";
            5, 6: return "R2/R4 shift";
            default: return "R3/R5/R6 compare";
        endcase
    endfunction

    // Drive on falling edge, check one capture edge later
    task automatic step_direct(input int op, input int x, input int y);
        @(negedge clk);
        en = 1'b1; use_instr = 1'b0; op_sel = 3'(op); a = 8'(x); b = 8'(y);
        instr = 16'h0000;   // not a valid word: direct mode must still work (R10)
        @(posedge clk); #1;
        exp_q = ref_op(op, x, y);
        check(op_tag(op), 16'(outs()), 16'(exp_q));
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin : main
        // R13: reset state
        repeat (2) @(negedge clk);
        check("R13 during reset", 16'(outs()), 16'h0);
        a = 8'hFF; b = 8'h01; en = 1'b1;
        @(posedge clk); #1;
        check("R13 reset ignores capture", 16'(outs()), 16'h0);
        @(negedge clk); rst_n = 1'b1; en = 1'b0;

        // Sweep: all ops x 32 values of a x all 256 values of b
        for (int op = 0; op < 8; op++)
            for (int j = 0; j < 32; j++)
                for (int y = 0; y < 256; y++)
                    step_direct(op, (j * 8) | (j % 8), y);

        // R11: hold with en low
        step_direct(0, 8'h70, 8'h20);   // 0x90, N=1, V=1
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            en = 1'b0; op_sel = 3'(k + 2); a = 8'(k * 40); b = 8'(k + 9);
            @(posedge clk); #1;
            check("R11 hold when disabled", 16'(outs()), 16'(exp_q));
        end

        // Instruction mode: all 64 top-field values
        for (int p = 0; p < 64; p++) begin
            logic [15:0] w;
            int xp, yp, exp_op;
            logic ok;
            w  = {6'(p), 1'(p % 2), 1'((p / 2) % 2 == 0), 4'(p + 3), 4'(p * 5)};
            xp = (p * 7 + 1) % 256;
            yp = (p * 3 + 200) % 256;
            case (6'(p))
                6'b000011: begin ok = 1'b1; exp_op = 0; end
                6'b000110: begin ok = 1'b1; exp_op = 1; end
                6'b001000: begin ok = 1'b1; exp_op = 2; end
                6'b001010: begin ok = 1'b1; exp_op = 3; end
                6'b001001: begin ok = 1'b1; exp_op = 4; end
                default:   begin ok = 1'b0; exp_op = 0; end
            endcase
            @(negedge clk);
            en = 1'b1; use_instr = 1'b1; op_sel = 3'd7; instr = w;
            a = 8'(xp); b = 8'(yp);
            #1;
            check("R8 decode valid", 16'(dec_valid), 16'(ok));
            check("R9 source index", 16'(src_idx), 16'({w[9], w[3:0]}));
            check("R9 destination index", 16'(dst_idx), 16'({w[8], w[7:4]}));
            @(posedge clk); #1;
            if (ok) begin
                exp_q = ref_op(exp_op, xp, yp);
                check("R10 decoded op used", 16'(outs()), 16'(exp_q));
            end else begin
                check("R12 unknown word holds", 16'(outs()), 16'(exp_q));
            end
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule